// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between the byte-level receiver of a serial memory slave and its non-volatile array. Once the receiver has decoded a word address, the block loads it into a shared word pointer. Each data byte that follows is placed into a page buffer at the slot named by the pointer's low bits, and the pointer then steps forward within the page. The block also keeps a per-slot mask of the bytes that arrived.

When the receiver reports a stop event, the block hands the buffered page to the array in one strobe. The strobe carries:

- the page base address,
- all buffered data,
- a byte-enable mask with one bit per slot.

The block then holds a busy flag for a fixed programming time. While busy it ignores every request.

A write-protect level blocks data acceptance, so a protected transaction never starts a programming cycle. The pointer is also brought out, because later current-address reads continue from it.

Top module: `page_commit_top`

## Requirements
- R1: After reset, `writeBusy`, `commitStrobe` and `commitByteEn` are all zero.
- R2: An accepted byte goes to the slot given by the low log2(PAGE_BYTES) bits of the pointer (slot k holds `commitData[8k+7:8k]`). The pointer low bits then add one modulo PAGE_BYTES, and the upper pointer bits never change.
- R3: When more than PAGE_BYTES bytes arrive in one transaction, the pointer wraps and the later bytes replace the earliest ones in their slots.
- R4: Bit k of `commitByteEn` is set exactly when slot k received a byte in the transaction. For every set bit, the committed data is the last byte written to that slot.
- R5: `commitStrobe` pulses for exactly one cycle, in the cycle after a stop event is sampled. It never pulses on a data byte. `commitAddr` is the pointer with its low log2(PAGE_BYTES) bits cleared.
- R6: A stop with no accepted byte since the last address load causes no strobe and no busy, and it leaves the pointer unchanged.
- R7: After a commit, `writeBusy` is high for exactly WRITE_CYCLES consecutive cycles, starting with the strobe cycle.
- R8: While `writeBusy` is high, address loads, data bytes and stop events are ignored, `byteAck` stays low, and the pointer keeps its value.
- R9: While `wpLevel` is high, `byteAck` is low, the byte is not stored, and a following stop starts no write cycle.
- R10: After a commit, `ptrOut` equals the last written address plus one, with the wrap confined to the page.
- R11: An address load clears the mask, so bytes from an earlier transaction that was never stopped are not committed.
- R12: `byteAck` is high in a cycle with `byteValid` high exactly when the block is idle, `wpLevel` is low and `addrLoad` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addrLoad | input | 1 | Word address received; load the pointer |
| addrIn | input | ADDR_W | Word address to load |
| byteValid | input | 1 | A complete data byte is present |
| byteData | input | 8 | The data byte |
| stopEvt | input | 1 | Stop event seen on the bus |
| wpLevel | input | 1 | Write-protect level, high blocks writes |
| byteAck | output | 1 | Byte will be accepted this cycle |
| writeBusy | output | 1 | Internal write cycle in progress |
| ptrOut | output | ADDR_W | Shared word address pointer |
| commitStrobe | output | 1 | One-cycle write strobe to the array |
| commitAddr | output | ADDR_W | Page base address of the commit |
| commitData | output | 8*PAGE_BYTES | Page data, slot k at bits 8k+7:8k |
| commitByteEn | output | PAGE_BYTES | Per-slot byte enable |

## Verification
The bench keeps PAGE_BYTES at 16 and ADDR_W at 11, but builds the block with WRITE_CYCLES set to 40 in place of a programming time measured in milliseconds. With this value, every busy window can be counted cycle by cycle, and many transactions fit in one run. Random transactions of zero to twenty bytes at random addresses, with write-protect sometimes set, exercise wrap, partial pages and blocked writes. Directed cases probe requests made during busy, a restart without a stop, and a stop issued right after an address with no data.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef struct packed {
    logic loadAddr;
    logic takeByte;
    logic commit;
  } pwStrobes_t;
endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pwStrobes_t              strb,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [7:0]              byteData,
  output logic [ADDR_W-1:0]       ptrOut,
  output logic                    anyValid,
  output logic                    commitStrobe,
  output logic [ADDR_W-1:0]       commitAddr,
  output logic [8*PAGE_BYTES-1:0] commitData,
  output logic [PAGE_BYTES-1:0]   commitByteEn
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic [7:0]              pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   validMask;
  logic [ADDR_W-1:0]       ptr;
  logic [OFS_W-1:0]        slot;
  logic [8*PAGE_BYTES-1:0] bufFlat;

  assign slot     = ptr[OFS_W-1:0];
  assign ptrOut   = ptr;
  assign anyValid = |validMask;

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_flat
    assign bufFlat[8*k +: 8] = pageBuf[k];
  end

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pageBuf[k] <= '0;
      else if (strb.takeByte && slot == OFS_W'(k)) pageBuf[k] <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      validMask <= '0;
    end else if (strb.loadAddr) begin
      ptr       <= addrIn;
      validMask <= '0;
    end else if (strb.takeByte) begin
      ptr[OFS_W-1:0]  <= slot + 1'b1;
      validMask[slot] <= 1'b1;
    end else if (strb.commit) begin
      validMask <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commitStrobe <= 1'b0;
      commitAddr   <= '0;
      commitData   <= '0;
      commitByteEn <= '0;
    end else begin
      commitStrobe <= strb.commit;
      if (strb.commit) begin
        commitAddr   <= {ptr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        commitData   <= bufFlat;
        commitByteEn <= validMask;
      end
    end
  end

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.takeByte |=> ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W])); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commitStrobe |=> !commitStrobe); // R5
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadAddr |=> !anyValid); // R11
endmodule

// File: rtl/pw_control.sv
module pw_control
  import pw_pkg::*;
#(
  parameter int WRITE_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addrLoad,
  input  logic       byteValid,
  input  logic       stopEvt,
  input  logic       wpLevel,
  input  logic       anyValid,
  output pwStrobes_t strb,
  output logic       writeBusy,
  output logic       byteAck
);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  logic             busy;
  logic [TMR_W-1:0] timer;
  logic             idle;

  assign idle      = !busy;
  assign writeBusy = busy;

  always_comb begin
    strb          = '0;
    strb.loadAddr = idle && addrLoad;
    strb.takeByte = idle && !addrLoad && byteValid && !wpLevel;
    strb.commit   = idle && !addrLoad && !byteValid && stopEvt && anyValid;
  end

  assign byteAck = strb.takeByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (strb.commit) begin
      busy  <= 1'b1;
      timer <= TMR_W'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (timer == '0) busy <= 1'b0;
      else timer <= timer - 1'b1;
    end
  end

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> busy); // R7
  AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |-> anyValid); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byteAck && !strb.loadAddr && !strb.commit); // R8
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wpLevel |-> !byteAck); // R9
endmodule

// File: rtl/page_commit_top.sv
module page_commit_top
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addrLoad,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  input  logic                    stopEvt,
  input  logic                    wpLevel,
  output logic                    byteAck,
  output logic                    writeBusy,
  output logic [ADDR_W-1:0]       ptrOut,
  output logic                    commitStrobe,
  output logic [ADDR_W-1:0]       commitAddr,
  output logic [8*PAGE_BYTES-1:0] commitData,
  output logic [PAGE_BYTES-1:0]   commitByteEn
);
  pwStrobes_t strb;
  logic       anyValid;

  pw_control #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addrLoad(addrLoad), .byteValid(byteValid),
    .stopEvt(stopEvt), .wpLevel(wpLevel), .anyValid(anyValid),
    .strb(strb), .writeBusy(writeBusy), .byteAck(byteAck)
  );

  pw_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addrIn(addrIn), .byteData(byteData),
    .ptrOut(ptrOut), .anyValid(anyValid), .commitStrobe(commitStrobe),
    .commitAddr(commitAddr), .commitData(commitData), .commitByteEn(commitByteEn)
  );

  AST_STROBE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commitStrobe |-> writeBusy); // R7
  AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    writeBusy && $past(writeBusy) |-> $stable(ptrOut)); // R8
endmodule

// File: tb/page_commit_top_tb_top.sv
module page_commit_top_tb_top;
  localparam int AW = 11;
  localparam int PB = 16;
  localparam int WC = 40;

  logic clk = 0, rst_n = 0;
  logic addrLoad = 0, byteValid = 0, stopEvt = 0, wpLevel = 0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0] byteData = '0;
  logic byteAck, writeBusy, commitStrobe;
  logic [AW-1:0] ptrOut, commitAddr;
  logic [8*PB-1:0] commitData;
  logic [PB-1:0] commitByteEn;

  int checks = 0, errors = 0;
  logic [7:0] mBuf [PB];
  logic [PB-1:0] mMask = '0;
  logic [AW-1:0] mPtr = '0;
  logic mBusy = 0;

  always #4 clk = ~clk;

  page_commit_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteValid(byteValid), .byteData(byteData), .stopEvt(stopEvt), .wpLevel(wpLevel),
    .byteAck(byteAck), .writeBusy(writeBusy), .ptrOut(ptrOut),
    .commitStrobe(commitStrobe), .commitAddr(commitAddr),
    .commitData(commitData), .commitByteEn(commitByteEn)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return {p[AW-1:4], p[3:0] + 4'd1};
  endfunction

  task automatic loadA(input logic [AW-1:0] a);
    @(negedge clk); addrLoad = 1; addrIn = a;
    @(negedge clk); addrLoad = 0;
    if (!mBusy) begin mPtr = a; mMask = '0; end
    chk("R11 ptr load", ptrOut, mPtr);
  endtask

  task automatic putByte(input logic [7:0] d);
    logic expAck;
    @(negedge clk); byteValid = 1; byteData = d;
    expAck = !wpLevel && !mBusy;
    #1 chk("R12/R9/R8 byteAck", byteAck, expAck);
    @(negedge clk); byteValid = 0;
    if (expAck) begin
      mBuf[mPtr[3:0]] = d; mMask[mPtr[3:0]] = 1'b1; mPtr = nextPtr(mPtr);
    end
    chk("R2 ptr step", ptrOut, mPtr);
    chk("R5 no strobe on byte", commitStrobe, 1'b0);
  endtask

  task automatic stopT(input bit countBusy);
    logic expC;
    @(negedge clk); stopEvt = 1;
    @(negedge clk); stopEvt = 0;
    expC = (mMask != 0) && !mBusy;
    chk("R5/R6 strobe", commitStrobe, expC);
    chk("R6/R10 ptr after stop", ptrOut, mPtr);
    if (expC) begin
      chk("R4 byteEn", commitByteEn, mMask);
      chk("R5 commitAddr", commitAddr, {mPtr[AW-1:4], 4'h0});
      for (int k = 0; k < PB; k++)
        if (mMask[k]) chk("R3/R4 data", commitData[8*k +: 8], mBuf[k]);
      mMask = '0; mBusy = 1;
      if (countBusy) begin
        int n = 0;
        while (writeBusy && n < WC + 5) begin n++; @(negedge clk); end
        chk("R7 busy length", n, WC);
        mBusy = 0;
      end
    end else begin
      chk("R6 no busy", writeBusy, 1'b0);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (writeBusy && n < WC + 5) begin n++; @(negedge clk); end
    mBusy = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int k = 0; k < PB; k++) mBuf[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy reset", writeBusy, 1'b0);
    chk("R1 strobe reset", commitStrobe, 1'b0);
    chk("R1 byteEn reset", commitByteEn, '0);
    rst_n = 1;

    // R2 R4: partial page mid-page
    loadA(11'h125);
    for (int i = 0; i < 3; i++) putByte(8'hA0 + 8'(i));
    stopT(1);
    // R3: wrap, 18 bytes from offset 14
    loadA(11'h3FE);
    for (int i = 0; i < 18; i++) putByte(8'(i + 1));
    stopT(1);
    // R6: stop with no data
    loadA(11'h044);
    stopT(1);
    // R8: requests during busy
    loadA(11'h200); putByte(8'h55); stopT(0);
    loadA(11'h010); putByte(8'h66);
    @(negedge clk); stopEvt = 1; @(negedge clk); stopEvt = 0;
    chk("R8 no strobe while busy", commitStrobe, 1'b0);
    chk("R8 ptr held", ptrOut, mPtr);
    waitIdle();
    // R11: restart without stop
    loadA(11'h500); putByte(8'h11); putByte(8'h22);
    loadA(11'h508); putByte(8'h33);
    stopT(1);
    // R9: write protect
    wpLevel = 1;
    loadA(11'h600); putByte(8'h77); putByte(8'h78);
    stopT(1);
    wpLevel = 0;

    for (int t = 0; t < 60; t++) begin
      int nb;
      loadA(AW'($urandom % 2048));
      wpLevel = (($urandom % 5) == 0);
      nb = $urandom % 21;
      for (int i = 0; i < nb; i++) putByte(8'($urandom));
      stopT(1);
      wpLevel = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule